// File: doc/BRIEF.md
# Rendering Engine Control and Error Register Block

This block is the host-facing register set of a small vector rendering coprocessor. A host reaches it over a plain 32-bit register bus with a select, a write strobe, a byte address and write data; read data is returned in the same cycle. The block holds the run/halt bit, the page-bound-check enable and the error interrupt enable. It latches six error causes reported by the execution core and keeps them until software clears them, and it shows the core's live busy and queue-empty state.

It also keeps sticky records of engine activity: one bit notes that the engine performed a write, and one bit per quarter of the 128-entry register file notes that the engine wrote into that quarter. Two address windows forward host writes to the execution core. One writes the register file directly, which is legal only while the engine is halted. The other pushes pseudo-instructions that update registers through the instruction queue. A direct write attempted while the engine runs is discarded and recorded as an illegal register access. A diagnostics word with a fixed reset value is also held here.

Top module: `eng_ctl_csr`

## Requirements
- R1: After reset, go, page-check enable, interrupt enable, every cause bit, the write-performed bit and the bank bits are 0, irq_o is 0, and the diagnostics word is 0x4804.
- R2: Writing the control word (offset 0x000) loads bit 7 (interrupt enable), bit 10 (page-bound check enable, driven on page_chk_o) and bit 12 (go, driven on go_o). All three read back at the same positions.
- R3: A pulse on core_err_i[k] latches cause k: 0 illegal instruction, 1 page bound, 2 illegal memory access, 3 illegal register access, 4 alignment, 5 illegal queue write. Causes read at bits 5:0 of both the control word and the error word (offset 0x004), and writing 1 to such a bit at either offset clears it. A set and a clear of the same bit in the same cycle leave it set.
- R4: A pulse on core_wrote_i sets control bit 11. Writing 1 to bit 11 clears it, and a set in the same cycle wins.
- R5: An engine register write (core_rf_we_i) at index i sets control bit 16 + i/32, one bit per block of 32 registers. These bits are cleared by writing 1 to them, and a set in the same cycle wins.
- R6: irq_o is 1 exactly when the interrupt enable is 1 and at least one cause is latched. It changes at the same edge as those bits, and it reads back at bit 7 of the error word. Writes to error-word bits other than 5:0 have no effect.
- R7: A host write to 0x100 + 4·r while go is 0 asserts rf_we_o in that cycle, with rf_idx_o = r and rf_data_o equal to the write data.
- R8: A host write to 0x100 + 4·r while go is 1 leaves rf_we_o at 0 and sets cause 3.
- R9: A host write to 0x300 + 4·r asserts q_we_o in that cycle with q_idx_o = r and q_data_o equal to the write data, whatever the value of go. It never coincides with rf_we_o.
- R10: Control bit 14 reads the live core_q_empty_i and bit 15 reads the live core_busy_i.
- R11: The diagnostics word (offset 0x008) is read/write in its low 16 bits, its upper bits read 0, and diag_o shows it.
- R12: Reads return 0 for unused bits, for unmapped offsets, for both write windows and while bus_we is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| core_err_i | input | 6 | Error cause pulses from the core |
| core_wrote_i | input | 1 | Engine performed a write |
| core_rf_we_i | input | 1 | Engine wrote its register file |
| core_rf_idx_i | input | 7 | Index of that engine write |
| core_busy_i | input | 1 | Core executing or instruction pending |
| core_q_empty_i | input | 1 | Instruction queue empty |
| go_o | output | 1 | Engine run enable |
| page_chk_o | output | 1 | Page-bound check enable |
| irq_o | output | 1 | Error interrupt |
| diag_o | output | 16 | Diagnostics word |
| rf_we_o | output | 1 | Direct register-file write strobe |
| rf_idx_o | output | 7 | Direct write register index |
| rf_data_o | output | 32 | Direct write data |
| q_we_o | output | 1 | Queued register write strobe |
| q_idx_o | output | 7 | Queued write register index |
| q_data_o | output | 32 | Queued write data |

## Verification
The assertions check on every cycle the invariants that need no scenario. A sticky bit with a pending set is 1 after the edge, a cleared bit falls, an untouched bit holds, direct writes never pass while go is 1, the two write strobes never coincide, irq_o matches the enable and the cause bits, and a discarded direct write always leaves cause 3 latched. Only the bench's scenarios show the bit positions and offsets seen from the bus, the mapping of register indices to banks at the 31/32 and 127 edges, the reset values, and that the error word clears the same causes as the control word. The bench mixes random bus traffic and core events against a reference model with directed collisions and window edges.

// File: rtl/eng_csr_pkg.sv
`timescale 1ns/1ps
package eng_csr_pkg;

   localparam int CAUSE_N = 6;

   // cause bit indices
   localparam int CZ_ILL_INSTR = 0;
   localparam int CZ_PAGE      = 1;
   localparam int CZ_BAD_MEM   = 2;
   localparam int CZ_BAD_REG   = 3;
   localparam int CZ_ALIGN     = 4;
   localparam int CZ_Q_WRITE   = 5;

   // control word bit positions
   localparam int CB_IRQ_EN   = 7;
   localparam int CB_PAGE_CHK = 10;
   localparam int CB_WROTE    = 11;
   localparam int CB_GO       = 12;
   localparam int CB_Q_EMPTY  = 14;
   localparam int CB_BUSY     = 15;
   localparam int CB_BANK0    = 16;

   // error word bit position
   localparam int EB_IRQ = 7;

   // byte offsets
   localparam logic [31:0] OFS_CTRL    = 32'h0000_0000;
   localparam logic [31:0] OFS_ERR     = 32'h0000_0004;
   localparam logic [31:0] OFS_DIAG    = 32'h0000_0008;
   localparam logic [31:0] DIRECT_BASE = 32'h0000_0100;
   localparam logic [31:0] QUEUE_BASE  = 32'h0000_0300;

   typedef enum logic [2:0] {
      HIT_NONE,
      HIT_CTRL,
      HIT_ERR,
      HIT_DIAG,
      HIT_DIRECT,
      HIT_QUEUED
   } hit_e;

endpackage

// File: rtl/eng_csr_decode.sv
`timescale 1ns/1ps
module eng_csr_decode
   import eng_csr_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int IDX_W  = 7
) (
   input  logic [ADDR_W-1:0] addr_i,
   output hit_e              hit_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam logic [31:0] SPAN = 32'(4 * (2 ** IDX_W));

   logic [31:0] a32;
   logic [31:0] dir_off;
   logic [31:0] que_off;

   always_comb begin
      a32     = 32'(addr_i);
      dir_off = a32 - DIRECT_BASE;
      que_off = a32 - QUEUE_BASE;
      hit_o   = HIT_NONE;
      idx_o   = '0;
      if (a32 == OFS_CTRL) begin
         hit_o = HIT_CTRL;
      end else if (a32 == OFS_ERR) begin
         hit_o = HIT_ERR;
      end else if (a32 == OFS_DIAG) begin
         hit_o = HIT_DIAG;
      end else if (a32 >= DIRECT_BASE && a32 < DIRECT_BASE + SPAN) begin
         hit_o = HIT_DIRECT;
         idx_o = dir_off[IDX_W+1:2];
      end else if (a32 >= QUEUE_BASE && a32 < QUEUE_BASE + SPAN) begin
         hit_o = HIT_QUEUED;
         idx_o = que_off[IDX_W+1:2];
      end
   end

endmodule

// File: rtl/eng_csr_bank_track.sv
`timescale 1ns/1ps
module eng_csr_bank_track #(
   parameter int IDX_W     = 7,
   parameter int NUM_BANKS = 4
) (
   input  logic                 we_i,
   input  logic [IDX_W-1:0]     idx_i,
   output logic [NUM_BANKS-1:0] hit_o
);
   localparam int BANK_W = $clog2(NUM_BANKS);

   if (NUM_BANKS < 2) begin : g_bad_banks
      $error("eng_csr_bank_track: NUM_BANKS must be at least 2");
   end

   logic [BANK_W-1:0] bank_sel;
   assign bank_sel = idx_i[IDX_W-1 -: BANK_W];

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign hit_o[b] = we_i && (bank_sel == BANK_W'(b));
   end

endmodule

// File: rtl/eng_csr_sticky.sv
`timescale 1ns/1ps
module eng_csr_sticky #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o,
   output logic [W-1:0] d_o
);
   if (W < 1) begin : g_bad_w
      $error("eng_csr_sticky: W must be positive");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic bit_q;
      logic bit_d;
      assign bit_d = set_i[i] | (bit_q & ~clr_i[i]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) bit_q <= 1'b0;
         else        bit_q <= bit_d;
      end
      assign q_o[i] = bit_q;
      assign d_o[i] = bit_d;
   end

   // R3 (also R4, R5): a pending set is visible after the edge, even against a clear
   a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));

   // R3 (also R4, R5): write-one-to-clear drops the bit when no set competes
   a_r3_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

   // R3 (also R4, R5): no set and no clear keeps the bits
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i == '0 && clr_i == '0) |=> $stable(q_o));

endmodule

// File: rtl/eng_ctl_csr.sv
`timescale 1ns/1ps
module eng_ctl_csr
   import eng_csr_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          RF_DEPTH   = 128,
   parameter int          IDX_W      = $clog2(RF_DEPTH),
   parameter int          NUM_BANKS  = 4,
   parameter int          DIAG_W     = 16,
   parameter logic [31:0] DIAG_RESET = 32'h0000_4804
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [CAUSE_N-1:0] core_err_i,
   input  logic              core_wrote_i,
   input  logic              core_rf_we_i,
   input  logic [IDX_W-1:0]  core_rf_idx_i,
   input  logic              core_busy_i,
   input  logic              core_q_empty_i,
   output logic              go_o,
   output logic              page_chk_o,
   output logic              irq_o,
   output logic [DIAG_W-1:0] diag_o,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_idx_o,
   output logic [31:0]       rf_data_o,
   output logic              q_we_o,
   output logic [IDX_W-1:0]  q_idx_o,
   output logic [31:0]       q_data_o
);
   // ---------------- elaboration checks ----------------
   if ((RF_DEPTH & (RF_DEPTH - 1)) != 0 || RF_DEPTH < 2) begin : g_bad_depth
      $error("eng_ctl_csr: RF_DEPTH must be a power of two");
   end
   if (IDX_W != $clog2(RF_DEPTH)) begin : g_bad_idx
      $error("eng_ctl_csr: IDX_W must equal clog2(RF_DEPTH)");
   end
   if ((NUM_BANKS & (NUM_BANKS - 1)) != 0 || NUM_BANKS < 2 ||
       NUM_BANKS > 12 || NUM_BANKS > RF_DEPTH) begin : g_bad_banks
      $error("eng_ctl_csr: NUM_BANKS must be a power of two in 2..12");
   end
   if (DIAG_W < 1 || DIAG_W > 32) begin : g_bad_diag
      $error("eng_ctl_csr: DIAG_W must be 1..32");
   end
   if (ADDR_W > 31 ||
       (64'(QUEUE_BASE) + 64'(4 * RF_DEPTH)) > (64'(1) << ADDR_W)) begin : g_bad_addr
      $error("eng_ctl_csr: ADDR_W too small for the write windows");
   end

   // ---------------- decode ----------------
   hit_e             hit;
   logic [IDX_W-1:0] widx;

   eng_csr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
      .addr_i (bus_addr),
      .hit_o  (hit),
      .idx_o  (widx)
   );

   logic wr, rd;
   logic wr_ctrl, wr_err, wr_diag, wr_direct, wr_queued;
   assign wr        = bus_sel & bus_we;
   assign rd        = bus_sel & ~bus_we;
   assign wr_ctrl   = wr && (hit == HIT_CTRL);
   assign wr_err    = wr && (hit == HIT_ERR);
   assign wr_diag   = wr && (hit == HIT_DIAG);
   assign wr_direct = wr && (hit == HIT_DIRECT);
   assign wr_queued = wr && (hit == HIT_QUEUED);

   // ---------------- plain control bits ----------------
   logic ie_q, pb_q, go_q;
   logic ie_d;
   assign ie_d = wr_ctrl ? bus_wdata[CB_IRQ_EN] : ie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q <= 1'b0;
         pb_q <= 1'b0;
         go_q <= 1'b0;
      end else if (wr_ctrl) begin
         ie_q <= bus_wdata[CB_IRQ_EN];
         pb_q <= bus_wdata[CB_PAGE_CHK];
         go_q <= bus_wdata[CB_GO];
      end
   end

   // ---------------- sticky causes ----------------
   logic [CAUSE_N-1:0] cause_set, cause_clr, cause_q, cause_d;
   logic               drop_direct;
   assign drop_direct = wr_direct & go_q;

   always_comb begin
      cause_set = core_err_i;
      cause_set[CZ_BAD_REG] = core_err_i[CZ_BAD_REG] | drop_direct;
      cause_clr = (wr_ctrl | wr_err) ? bus_wdata[CAUSE_N-1:0] : '0;
   end

   eng_csr_sticky #(.W(CAUSE_N)) u_cause (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (cause_set),
      .clr_i (cause_clr),
      .q_o   (cause_q),
      .d_o   (cause_d)
   );

   // ---------------- write-performed flag ----------------
   logic wrote_q, wrote_d, wrote_clr;
   assign wrote_clr = wr_ctrl & bus_wdata[CB_WROTE];

   eng_csr_sticky #(.W(1)) u_wrote (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (core_wrote_i),
      .clr_i (wrote_clr),
      .q_o   (wrote_q),
      .d_o   (wrote_d)
   );

   // ---------------- bank-modified flags ----------------
   logic [NUM_BANKS-1:0] bank_set, bank_clr, bank_q, bank_d;

   eng_csr_bank_track #(.IDX_W(IDX_W), .NUM_BANKS(NUM_BANKS)) u_bank_track (
      .we_i  (core_rf_we_i),
      .idx_i (core_rf_idx_i),
      .hit_o (bank_set)
   );

   assign bank_clr = wr_ctrl ? bus_wdata[CB_BANK0 +: NUM_BANKS] : '0;

   eng_csr_sticky #(.W(NUM_BANKS)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (bank_set),
      .clr_i (bank_clr),
      .q_o   (bank_q),
      .d_o   (bank_d)
   );

   // ---------------- interrupt ----------------
   logic irq_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= ie_d & (|cause_d);
   end

   // ---------------- diagnostics ----------------
   logic [DIAG_W-1:0] diag_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       diag_q <= DIAG_RESET[DIAG_W-1:0];
      else if (wr_diag) diag_q <= bus_wdata[DIAG_W-1:0];
   end

   // ---------------- read mux ----------------
   logic [31:0] ctrl_word, err_word, diag_word;
   always_comb begin
      ctrl_word = '0;
      ctrl_word[CAUSE_N-1:0]            = cause_q;
      ctrl_word[CB_IRQ_EN]              = ie_q;
      ctrl_word[CB_PAGE_CHK]            = pb_q;
      ctrl_word[CB_WROTE]               = wrote_q;
      ctrl_word[CB_GO]                  = go_q;
      ctrl_word[CB_Q_EMPTY]             = core_q_empty_i;
      ctrl_word[CB_BUSY]                = core_busy_i;
      ctrl_word[CB_BANK0 +: NUM_BANKS]  = bank_q;
      err_word = '0;
      err_word[CAUSE_N-1:0]             = cause_q;
      err_word[EB_IRQ]                  = irq_q;
      diag_word = '0;
      diag_word[DIAG_W-1:0]             = diag_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         unique case (hit)
            HIT_CTRL: bus_rdata = ctrl_word;
            HIT_ERR:  bus_rdata = err_word;
            HIT_DIAG: bus_rdata = diag_word;
            default:  bus_rdata = '0;
         endcase
      end
   end

   // ---------------- outputs ----------------
   assign go_o       = go_q;
   assign page_chk_o = pb_q;
   assign irq_o      = irq_q;
   assign diag_o     = diag_q;
   assign rf_we_o    = wr_direct & ~go_q;
   assign rf_idx_o   = widx;
   assign rf_data_o  = bus_wdata;
   assign q_we_o     = wr_queued;
   assign q_idx_o    = widx;
   assign q_data_o   = bus_wdata;

   // ---------------- assertions ----------------
   // R7: the direct window never passes a write while the engine runs
   a_r7_only_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o |-> !go_o);

   // R8: a discarded direct write leaves the illegal register access cause latched
   a_r8_drop_sets_cause: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && hit == HIT_DIRECT && go_o) |=> cause_q[CZ_BAD_REG]);

   // R9: direct and queued strobes are exclusive
   a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rf_we_o, q_we_o}));

   // R6: interrupt only with enable and a latched cause
   a_r6_irq_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (ie_q && (cause_q != '0)));

   // R6: enable plus a latched cause always shows on irq_o
   a_r6_irq_present: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_q && (cause_q != '0)) |-> irq_o);

   // R2: run bit changes only through a control write
   a_r2_go_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_we && hit == HIT_CTRL) |=> $stable(go_o));

endmodule

// File: tb/eng_ctl_csr_bench.sv
`timescale 1ns/1ps
module eng_ctl_csr_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [5:0]  core_err_i = '0;
   logic        core_wrote_i = 1'b0;
   logic        core_rf_we_i = 1'b0;
   logic [6:0]  core_rf_idx_i = '0;
   logic        core_busy_i = 1'b0;
   logic        core_q_empty_i = 1'b1;
   logic        go_o, page_chk_o, irq_o;
   logic [15:0] diag_o;
   logic        rf_we_o, q_we_o;
   logic [6:0]  rf_idx_o, q_idx_o;
   logic [31:0] rf_data_o, q_data_o;

   always #2 clk = ~clk;

   eng_ctl_csr u_eng_ctl_csr (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .core_err_i(core_err_i), .core_wrote_i(core_wrote_i),
      .core_rf_we_i(core_rf_we_i), .core_rf_idx_i(core_rf_idx_i),
      .core_busy_i(core_busy_i), .core_q_empty_i(core_q_empty_i),
      .go_o(go_o), .page_chk_o(page_chk_o), .irq_o(irq_o), .diag_o(diag_o),
      .rf_we_o(rf_we_o), .rf_idx_o(rf_idx_o), .rf_data_o(rf_data_o),
      .q_we_o(q_we_o), .q_idx_o(q_idx_o), .q_data_o(q_data_o)
   );

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic [5:0]  m_cause = '0;
   logic        m_ie = 0, m_pb = 0, m_go = 0, m_wrote = 0, m_irq = 0;
   logic [3:0]  m_bank = '0;
   logic [15:0] m_diag = 16'h4804;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic in_direct(input logic [11:0] a);
      return (a >= 12'h100) && (a < 12'h300);
   endfunction

   function automatic logic in_queue(input logic [11:0] a);
      return (a >= 12'h300) && (a < 12'h500);
   endfunction

   // one bus/core cycle: drive at negedge, check combinational, update model, check registered
   task automatic cyc(input logic sel, input logic we, input logic [11:0] a,
                      input logic [31:0] wd, input logic [5:0] ce, input logic cw,
                      input logic rfe, input logic [6:0] ridx,
                      input logic bz, input logic qe);
      logic dir, que, wctrl, werr, wdiag;
      logic [5:0] setc, clrc;
      logic [3:0] setb, clrb;
      bus_sel = sel; bus_we = we; bus_addr = a; bus_wdata = wd;
      core_err_i = ce; core_wrote_i = cw; core_rf_we_i = rfe; core_rf_idx_i = ridx;
      core_busy_i = bz; core_q_empty_i = qe;
      dir   = sel && we && in_direct(a);
      que   = sel && we && in_queue(a);
      wctrl = sel && we && (a == 12'h000);
      werr  = sel && we && (a == 12'h004);
      wdiag = sel && we && (a == 12'h008);
      #1;
      if (sel && !we) begin
         if (a == 12'h000) begin
            chk("R3", {26'b0, bus_rdata[5:0]}, {26'b0, m_cause});
            chk("R2", {29'b0, bus_rdata[12], bus_rdata[10], bus_rdata[7]}, {29'b0, m_go, m_pb, m_ie});
            chk("R4", {31'b0, bus_rdata[11]}, {31'b0, m_wrote});
            chk("R10", {30'b0, bus_rdata[15:14]}, {30'b0, bz, qe});
            chk("R5", {28'b0, bus_rdata[19:16]}, {28'b0, m_bank});
            chk("R12", bus_rdata & 32'hFFF0_2340, 32'h0);
         end else if (a == 12'h004) begin
            chk("R6", bus_rdata, {24'b0, m_irq, 1'b0, m_cause});
         end else if (a == 12'h008) begin
            chk("R11", bus_rdata, {16'b0, m_diag});
         end else begin
            chk("R12", bus_rdata, 32'h0);
         end
      end else begin
         chk("R12", bus_rdata, 32'h0);
      end
      if (dir && m_go) chk("R8", {31'b0, rf_we_o}, 32'h0);
      else             chk("R7", {31'b0, rf_we_o}, {31'b0, dir});
      if (dir && !m_go) begin
         chk("R7", {25'b0, rf_idx_o}, {25'b0, 7'((a - 12'h100) >> 2)});
         chk("R7", rf_data_o, wd);
      end
      chk("R9", {31'b0, q_we_o}, {31'b0, que});
      if (que) begin
         chk("R9", {25'b0, q_idx_o}, {25'b0, 7'((a - 12'h300) >> 2)});
         chk("R9", q_data_o, wd);
      end
      @(posedge clk);
      setc = ce | ((dir && m_go) ? 6'b00_1000 : 6'b0);
      clrc = (wctrl || werr) ? wd[5:0] : 6'b0;
      m_cause = (m_cause & ~clrc) | setc;
      m_wrote = (m_wrote & ~(wctrl & wd[11])) | cw;
      setb = rfe ? (4'b0001 << ridx[6:5]) : 4'b0;
      clrb = wctrl ? wd[19:16] : 4'b0;
      m_bank = (m_bank & ~clrb) | setb;
      if (wctrl) begin
         m_ie = wd[7]; m_pb = wd[10]; m_go = wd[12];
      end
      if (wdiag) m_diag = wd[15:0];
      m_irq = m_ie & (|m_cause);
      @(negedge clk);
      chk("R2", {30'b0, go_o, page_chk_o}, {30'b0, m_go, m_pb});
      chk("R6", {31'b0, irq_o}, {31'b0, m_irq});
      chk("R11", {16'b0, diag_o}, {16'b0, m_diag});
   endtask

   task automatic idle_rd(input logic [11:0] a);
      cyc(1, 0, a, 32'h0, 6'h0, 0, 0, 7'h0, 0, 1);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      cyc(1, 1, a, d, 6'h0, 0, 0, 7'h0, 0, 1);
   endtask

   // watchdog
   initial begin
      #(4 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      bus_sel = 1; bus_we = 0; bus_addr = 12'h000; #1;
      chk("R1", bus_rdata, 32'h0000_4000);
      bus_addr = 12'h004; #1;
      chk("R1", bus_rdata, 32'h0);
      bus_addr = 12'h008; #1;
      chk("R1", bus_rdata, 32'h0000_4804);
      chk("R1", {29'b0, go_o, irq_o, page_chk_o}, 32'h0);
      chk("R1", {16'b0, diag_o}, 32'h0000_4804);
      @(negedge clk);

      // R10: live status bits
      cyc(1, 0, 12'h000, 0, 6'h0, 0, 0, 7'h0, 1, 0);

      // R3: set and clear of the same cause in one cycle, via the error word
      cyc(1, 0, 12'h000, 0, 6'h01, 0, 0, 7'h0, 0, 1);
      cyc(1, 1, 12'h004, 32'h0000_0001, 6'h01, 0, 0, 7'h0, 0, 1);
      idle_rd(12'h004);
      wr(12'h004, 32'hFFFF_FF80); // R6: bit 7 of error word ignored
      idle_rd(12'h004);
      wr(12'h000, 32'h0000_003F);  // R3: clear via control word
      idle_rd(12'h000);

      // R4: write flag collision
      cyc(1, 0, 12'h000, 0, 6'h0, 1, 0, 7'h0, 0, 1);
      cyc(1, 1, 12'h000, 32'h0000_0800, 6'h0, 1, 0, 7'h0, 0, 1);
      idle_rd(12'h000);

      // R5: bank edges 31, 32, 95, 96, 127
      cyc(1, 0, 12'h000, 0, 6'h0, 0, 1, 7'd31, 0, 1);
      cyc(1, 0, 12'h000, 0, 6'h0, 0, 1, 7'd32, 0, 1);
      idle_rd(12'h000);
      wr(12'h000, 32'h000F_0000);
      cyc(1, 0, 12'h000, 0, 6'h0, 0, 1, 7'd127, 0, 1);
      cyc(1, 0, 12'h000, 0, 6'h0, 0, 1, 7'd95, 0, 1);
      cyc(1, 0, 12'h000, 0, 6'h0, 0, 1, 7'd96, 0, 1);
      idle_rd(12'h000);

      // R7 / R8 / R9 / R6: direct and queued windows against go
      wr(12'h100, 32'hA5A5_0001);
      wr(12'h2FC, 32'hA5A5_007F);
      wr(12'h000, 32'h0000_1080);  // go=1, irq enable
      wr(12'h104, 32'hDEAD_BEEF);  // dropped, sets cause 3 -> irq
      idle_rd(12'h004);
      wr(12'h300, 32'h1234_5678);
      wr(12'h4FC, 32'h8765_4321);
      wr(12'h500, 32'h0BAD_0BAD);  // R12: outside both windows
      idle_rd(12'h2FC);
      wr(12'h000, 32'h0000_0008);  // stop, clear cause 3, disable irq
      idle_rd(12'h000);

      // R11: diagnostics
      wr(12'h008, 32'hFFFF_1234);
      idle_rd(12'h008);

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [11:0] a;
         logic [31:0] d;
         logic        sel, we;
         int          op;
         op  = $urandom_range(0, 9);
         d   = $urandom;
         sel = 1'b1;
         we  = 1'b1;
         case (op)
            0: sel = 1'b0;
            1, 2: begin
               we = 1'b0;
               case ($urandom_range(0, 4))
                  0: a = 12'h000;
                  1: a = 12'h004;
                  2: a = 12'h008;
                  3: a = 12'(12'h100 + 4 * $urandom_range(0, 255));
                  default: a = 12'(4 * $urandom_range(3, 63));
               endcase
            end
            3: a = 12'h000;
            4: a = 12'h004;
            5: a = 12'h008;
            6, 7: a = 12'(12'h100 + 4 * $urandom_range(0, 127));
            default: a = 12'(12'h300 + 4 * $urandom_range(0, 127));
         endcase
         if (op == 0) a = 12'h000;
         cyc(sel, we, a, d,
             ($urandom_range(0, 7) == 0) ? 6'($urandom) : 6'h0,
             ($urandom_range(0, 5) == 0),
             ($urandom_range(0, 3) == 0), 7'($urandom),
             1'($urandom), 1'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule